// File: doc/BRIEF.md
# Video pixel format adapter

This block sits on the pixel path between a video encoder and the pixel input of a display serial host. Each clock carries one pixel of three components, each up to 10 bits wide, together with data-enable, horizontal sync and vertical sync. The block corrects the polarity of the three timing signals and widens narrower input components to full lane width. It routes any input component to any of the three output channels and, for YCbCr 4:2:2 outputs, decimates chroma horizontally across even/odd pixel pairs. It then packs the result into the selected output word layout.

All format fields are static inputs that are captured only on the rising edge of the corrected vertical sync, so a frame is always processed with one consistent format. The three polarity bits act immediately. Data, enable and syncs leave the block exactly two clocks after they enter.

Top module: `pix_fmt_adapter`

## Requirements
- R1: While reset is asserted all outputs are 0. Until the first corrected VSYNC rising edge, the captured format is output format 0, 30-bit input, even chroma, and identity routing (channel k takes component k), whatever the format inputs hold.
- R2: `out_de`, `out_hs` and `out_vs` equal the corrected `pix_de`, `pix_hs` and `pix_vs` two clocks earlier. `out_data` is 0 whenever `out_de` is 0, and otherwise holds the formatted pixel presented two clocks earlier.
- R3: Setting `cfg_inv_de`, `cfg_inv_hs` or `cfg_inv_vs` to 1 inverts the matching input, so an active-low input becomes active-high inside the block. These bits take effect at once and are not captured at VSYNC.
- R4: Input width code 0 uses all 10 bits of each lane. Code 1 uses the low 8 bits and code 2 the low 6 bits. Code 3 uses 5/6/5 bits for components 0/1/2. The used bits are moved to the top of the 10-bit lane, the vacated low bits are zero, and unused upper input bits are ignored.
- R5: Channel selectors `cfg_sel_y`, `cfg_sel_cb` and `cfg_sel_cr` feed channels 0 (Y/R), 1 (Cb/G) and 2 (Cr/B). A value of 0, 1 or 2 picks that widened component, and 3 acts as 0.
- R6: RGB layouts (R=ch0, G=ch1, B=ch2, taking the top bits of each 10-bit channel; fields listed from MSB, result right-aligned in `out_data`, upper bits zero). Format 0 is {R5,G6,B5}. Format 1 is {000,R5,00,G6,000,B5}. Format 2 is {R5,000,G6,00,B5,000}. Format 3 is {R6,G6,B6}. Format 4 is {R6,00,G6,00,B6,00}. Format 5 is {R8,G8,B8}. Format 9 is {R10,G10,B10}. Format 10 is {R10,R[9:8],G10,G[9:8],B10,B[9:8]}.
- R7: YCbCr 4:2:2 layouts, with Y=ch0 and C the decimated chroma. Format 6 is {C10,Y10}, format 7 is {C10,C[9:8],Y10,Y[9:8]}, format 8 is {C[9:2],Y[9:2]}, and format 11 is {C[9:4],Y[9:4]}. On an even pixel C is the pair's Cb (from ch1); on an odd pixel C is the pair's Cr (from ch2).
- R8: Chroma mode 0 takes the even pixel's value and mode 1 the odd pixel's. Mode 2 gives (even + odd + 1) >> 1. Mode 3 acts as 0.
- R9: Pixel pairing restarts at every rising edge of the corrected DE, and the first active pixel of a line is even. If a line has an odd pixel count, the last pixel is paired with itself.
- R10: The format, width, chroma and selector fields are captured only on the clock edge where the corrected VSYNC is 1 and was 0 on the previous clock. Changes at any other time have no effect on the output.
- R11: Output formats 12 to 15 produce the format 9 layout {R10,G10,B10}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_out_fmt | input | 4 | Output word layout code |
| cfg_in_width | input | 2 | Input component width code |
| cfg_chroma_mode | input | 2 | Chroma decimation mode |
| cfg_sel_y | input | 2 | Source component for channel 0 |
| cfg_sel_cb | input | 2 | Source component for channel 1 |
| cfg_sel_cr | input | 2 | Source component for channel 2 |
| cfg_inv_de | input | 1 | Invert data-enable input |
| cfg_inv_hs | input | 1 | Invert horizontal sync input |
| cfg_inv_vs | input | 1 | Invert vertical sync input |
| pix_c0 | input | 10 | Input component 0 |
| pix_c1 | input | 10 | Input component 1 |
| pix_c2 | input | 10 | Input component 2 |
| pix_de | input | 1 | Input data enable |
| pix_hs | input | 1 | Input horizontal sync |
| pix_vs | input | 1 | Input vertical sync |
| out_data | output | 36 | Packed output pixel word |
| out_de | output | 1 | Active-high data enable, delayed |
| out_hs | output | 1 | Active-high horizontal sync, delayed |
| out_vs | output | 1 | Active-high vertical sync, delayed |

## Verification
The hardest case to reach from the ports is a line of odd length that ends on an even pixel. That pixel has no partner, and the very next clock is blanking that clears the pairing state. The stimulus therefore sends lines of 1 and 7 pixels in the odd-chroma and averaging modes, where a wrong partner changes the value. A second awkward case is a format change arriving mid-frame. The bench alters every captured field between two lines without a VSYNC edge and expects the old layout. It then toggles the polarity bits while keeping the logical sync low, so that inversion alone never creates a false capture edge.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
  parameter int PFA_CW = 10;
  localparam int PFA_XW = PFA_CW + 2;
  localparam int PFA_OW = 3 * PFA_XW;
  localparam int PFA_NCH = 3;

  typedef logic [PFA_CW-1:0] comp_t;
  typedef logic [PFA_OW-1:0] word_t;

  typedef enum logic [3:0] {
    OF_565_PK  = 4'd0,
    OF_565_LO  = 4'd1,
    OF_565_HI  = 4'd2,
    OF_666_PK  = 4'd3,
    OF_666_HI  = 4'd4,
    OF_888     = 4'd5,
    OF_YC_20   = 4'd6,
    OF_YC_24   = 4'd7,
    OF_YC_16   = 4'd8,
    OF_RGB_30  = 4'd9,
    OF_RGB_36  = 4'd10,
    OF_YC_12   = 4'd11
  } out_fmt_e;

  typedef struct packed {
    logic [3:0] fmt;
    logic [1:0] width;
    logic [1:0] chroma;
    logic [1:0] sel2;
    logic [1:0] sel1;
    logic [1:0] sel0;
  } cfg_t;

  localparam cfg_t PFA_CFG_RST = '{fmt: 4'd0, width: 2'd0, chroma: 2'd0,
                                   sel2: 2'd2, sel1: 2'd1, sel0: 2'd0};

  // Number of meaningful bits in a lane for a given width code.
  function automatic int unsigned lane_bits(logic [1:0] code, int unsigned lane);
    case (code)
      2'd1:    return 8;
      2'd2:    return 6;
      2'd3:    return (lane == 1) ? 6 : 5;
      default: return PFA_CW;
    endcase
  endfunction

  // Move the low 'bits' bits of raw to the top of the lane, zero below.
  function automatic comp_t lane_align(comp_t raw, int unsigned bits);
    comp_t r;
    r = '0;
    for (int unsigned k = 0; k < PFA_CW; k++) begin
      if (k < bits) r[PFA_CW - bits + k] = raw[k];
    end
    return r;
  endfunction

  // Pick or average the chroma of an even/odd pair.
  function automatic comp_t chroma_pick(logic [1:0] mode, comp_t ev, comp_t od);
    logic [PFA_CW:0] s;
    s = {1'b0, ev} + {1'b0, od} + {{PFA_CW{1'b0}}, 1'b1};
    case (mode)
      2'd1:    return od;
      2'd2:    return s[PFA_CW:1];
      default: return ev;
    endcase
  endfunction

  // Build the output word for one pixel.
  function automatic word_t pack_pixel(logic [3:0] fmt, comp_t c0, comp_t c1,
                                       comp_t c2, comp_t ch);
    word_t w;
    w = '0;
    case (fmt)
      OF_565_PK: w[15:0] = {c0[PFA_CW-1 -: 5], c1[PFA_CW-1 -: 6], c2[PFA_CW-1 -: 5]};
      OF_565_LO: w[23:0] = {3'b0, c0[PFA_CW-1 -: 5], 2'b0, c1[PFA_CW-1 -: 6],
                            3'b0, c2[PFA_CW-1 -: 5]};
      OF_565_HI: w[23:0] = {c0[PFA_CW-1 -: 5], 3'b0, c1[PFA_CW-1 -: 6], 2'b0,
                            c2[PFA_CW-1 -: 5], 3'b0};
      OF_666_PK: w[17:0] = {c0[PFA_CW-1 -: 6], c1[PFA_CW-1 -: 6], c2[PFA_CW-1 -: 6]};
      OF_666_HI: w[23:0] = {c0[PFA_CW-1 -: 6], 2'b0, c1[PFA_CW-1 -: 6], 2'b0,
                            c2[PFA_CW-1 -: 6], 2'b0};
      OF_888:    w[23:0] = {c0[PFA_CW-1 -: 8], c1[PFA_CW-1 -: 8], c2[PFA_CW-1 -: 8]};
      OF_RGB_36: w = {c0, c0[PFA_CW-1 -: 2], c1, c1[PFA_CW-1 -: 2], c2, c2[PFA_CW-1 -: 2]};
      OF_YC_20:  w[2*PFA_CW-1:0] = {ch, c0};
      OF_YC_24:  w[2*PFA_XW-1:0] = {ch, ch[PFA_CW-1 -: 2], c0, c0[PFA_CW-1 -: 2]};
      OF_YC_16:  w[15:0] = {ch[PFA_CW-1 -: 8], c0[PFA_CW-1 -: 8]};
      OF_YC_12:  w[11:0] = {ch[PFA_CW-1 -: 6], c0[PFA_CW-1 -: 6]};
      default:   w[3*PFA_CW-1:0] = {c0, c1, c2};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pfa_cfg_latch.sv
module pfa_cfg_latch import pfa_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic inv_de,
  input  logic inv_hs,
  input  logic inv_vs,
  input  logic raw_de,
  input  logic raw_hs,
  input  logic raw_vs,
  input  cfg_t cfg_d,
  output logic de_o,
  output logic hs_o,
  output logic vs_o,
  output cfg_t cfg_q
);
  logic vs_prev;
  logic vs_rise;

  assign de_o = raw_de ^ inv_de;
  assign hs_o = raw_hs ^ inv_hs;
  assign vs_o = raw_vs ^ inv_vs;
  assign vs_rise = vs_o & ~vs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_prev <= 1'b0;
      cfg_q   <= PFA_CFG_RST;
    end else begin
      vs_prev <= vs_o;
      if (vs_rise) cfg_q <= cfg_d;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/pfa_lane_route.sv
module pfa_lane_route import pfa_pkg::*; (
  input  comp_t [PFA_NCH-1:0] raw,
  input  logic  [1:0]         width,
  input  logic  [1:0]         sel0,
  input  logic  [1:0]         sel1,
  input  logic  [1:0]         sel2,
  output comp_t [PFA_NCH-1:0] ch
);
  comp_t [PFA_NCH-1:0]      aligned;
  logic  [PFA_NCH-1:0][1:0] sel;

  assign sel = {sel2, sel1, sel0};

  for (genvar g = 0; g < PFA_NCH; g++) begin : g_lane
    assign aligned[g] = lane_align(raw[g], lane_bits(width, g));
    assign ch[g] = (sel[g] == 2'd1) ? aligned[1] :
                   (sel[g] == 2'd2) ? aligned[2] : aligned[0];
  end
endmodule

// File: rtl/pfa_chroma_pair.sv
module pfa_chroma_pair import pfa_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  comp_t [PFA_NCH-1:0] cur,
  input  logic                de_i,
  input  logic                hs_i,
  input  logic                vs_i,
  input  logic  [1:0]         mode,
  output comp_t [PFA_NCH-1:0] h_pix,
  output comp_t               h_chroma,
  output logic                h_de,
  output logic                h_hs,
  output logic                h_vs
);
  logic  odd_run;
  logic  h_odd;
  logic  partner_ok;
  comp_t cr_save;
  comp_t o_cb, o_cr, cb_dec, cr_dec;

  // The current input is the odd mate of an even pixel held in stage one.
  assign partner_ok = de_i & odd_run;
  assign o_cb   = partner_ok ? cur[1] : h_pix[1];
  assign o_cr   = partner_ok ? cur[2] : h_pix[2];
  assign cb_dec = chroma_pick(mode, h_pix[1], o_cb);
  assign cr_dec = chroma_pick(mode, h_pix[2], o_cr);
  assign h_chroma = h_odd ? cr_save : cb_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_run <= 1'b0;
      h_odd   <= 1'b0;
      h_pix   <= '0;
      h_de    <= 1'b0;
      h_hs    <= 1'b0;
      h_vs    <= 1'b0;
      cr_save <= '0;
    end else begin
      odd_run <= de_i ? ~odd_run : 1'b0;
      h_odd   <= de_i & odd_run;
      h_pix   <= cur;
      h_de    <= de_i;
      h_hs    <= hs_i;
      h_vs    <= vs_i;
      if (h_de && !h_odd) cr_save <= cr_dec;
    end
  end

  AST_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_i) |=> (h_de && !h_odd)); // R9
  AST_PAIR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_de && !h_odd && de_i) |=> (h_de && h_odd)); // R9
  AST_CR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_de && h_odd) |=> $stable(cr_save)); // R8
endmodule

// File: rtl/pix_fmt_adapter.sv
module pix_fmt_adapter import pfa_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_out_fmt,
  input  logic [1:0]        cfg_in_width,
  input  logic [1:0]        cfg_chroma_mode,
  input  logic [1:0]        cfg_sel_y,
  input  logic [1:0]        cfg_sel_cb,
  input  logic [1:0]        cfg_sel_cr,
  input  logic              cfg_inv_de,
  input  logic              cfg_inv_hs,
  input  logic              cfg_inv_vs,
  input  logic [PFA_CW-1:0] pix_c0,
  input  logic [PFA_CW-1:0] pix_c1,
  input  logic [PFA_CW-1:0] pix_c2,
  input  logic              pix_de,
  input  logic              pix_hs,
  input  logic              pix_vs,
  output logic [PFA_OW-1:0] out_data,
  output logic              out_de,
  output logic              out_hs,
  output logic              out_vs
);
  cfg_t                cfg_d, cfg_q;
  logic                de_c, hs_c, vs_c;
  comp_t [PFA_NCH-1:0] routed;
  comp_t [PFA_NCH-1:0] h_pix;
  comp_t               h_chroma;
  logic                h_de, h_hs, h_vs;
  word_t               packed_w;

  assign cfg_d = '{fmt: cfg_out_fmt, width: cfg_in_width, chroma: cfg_chroma_mode,
                   sel2: cfg_sel_cr, sel1: cfg_sel_cb, sel0: cfg_sel_y};

  pfa_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n),
    .inv_de(cfg_inv_de), .inv_hs(cfg_inv_hs), .inv_vs(cfg_inv_vs),
    .raw_de(pix_de), .raw_hs(pix_hs), .raw_vs(pix_vs),
    .cfg_d(cfg_d),
    .de_o(de_c), .hs_o(hs_c), .vs_o(vs_c),
    .cfg_q(cfg_q)
  );

  pfa_lane_route u_route (
    .raw({pix_c2, pix_c1, pix_c0}),
    .width(cfg_q.width),
    .sel0(cfg_q.sel0), .sel1(cfg_q.sel1), .sel2(cfg_q.sel2),
    .ch(routed)
  );

  pfa_chroma_pair u_pair (
    .clk(clk), .rst_n(rst_n),
    .cur(routed), .de_i(de_c), .hs_i(hs_c), .vs_i(vs_c),
    .mode(cfg_q.chroma),
    .h_pix(h_pix), .h_chroma(h_chroma),
    .h_de(h_de), .h_hs(h_hs), .h_vs(h_vs)
  );

  assign packed_w = pack_pixel(cfg_q.fmt, h_pix[0], h_pix[1], h_pix[2], h_chroma);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_de   <= 1'b0;
      out_hs   <= 1'b0;
      out_vs   <= 1'b0;
    end else begin
      out_data <= h_de ? packed_w : '0;
      out_de   <= h_de;
      out_hs   <= h_hs;
      out_vs   <= h_vs;
    end
  end

  AST_DE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    h_de |=> out_de); // R2
  AST_VS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    h_vs |=> out_vs); // R2
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> (out_data == '0)); // R2
endmodule

// File: tb/tb_pix_fmt_adapter.sv
`timescale 1ns/1ps
module tb_pix_fmt_adapter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  cfg_out_fmt = 4'd9;
  logic [1:0]  cfg_in_width = 2'd2, cfg_chroma_mode = 2'd1;
  logic [1:0]  cfg_sel_y = 2'd2, cfg_sel_cb = 2'd0, cfg_sel_cr = 2'd1;
  logic        cfg_inv_de = 1'b0, cfg_inv_hs = 1'b0, cfg_inv_vs = 1'b0;
  logic [9:0]  pix_c0 = '0, pix_c1 = '0, pix_c2 = '0;
  logic        pix_de = 1'b0, pix_hs = 1'b0, pix_vs = 1'b0;
  logic [35:0] out_data;
  logic        out_de, out_hs, out_vs;

  pix_fmt_adapter dut (.*);

  typedef struct {
    int          tgt;
    logic        de, hs, vs;
    logic [35:0] data;
    string       ctag, dtag;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  // model state: captured format
  logic [3:0] m_fmt = 4'd0;
  logic [1:0] m_wid = 2'd0, m_chr = 2'd0;
  logic [1:0] m_sel[3] = '{2'd0, 2'd1, 2'd2};

  function automatic logic [9:0] m_align(logic [9:0] raw, logic [1:0] wid, int lane);
    int nb, v;
    nb = (wid == 0) ? 10 : (wid == 1) ? 8 : (wid == 2) ? 6 : ((lane == 1) ? 6 : 5);
    v = int'(raw) % (1 << nb);
    v = v * (1 << (10 - nb));
    return 10'(v);
  endfunction

  function automatic logic [9:0] m_pick(logic [1:0] md, logic [9:0] e, logic [9:0] o);
    int s;
    s = (int'(e) + int'(o) + 1) / 2;
    if (md == 2'd1) return o;
    if (md == 2'd2) return 10'(s);
    return e;
  endfunction

  function automatic logic [35:0] m_ext(logic [35:0] x);
    return (x << 2) | (x >> 8);
  endfunction

  function automatic logic [35:0] m_pack(logic [3:0] f, logic [9:0] r0, logic [9:0] g0,
                                         logic [9:0] b0, logic [9:0] c0);
    logic [35:0] r, g, b, c;
    r = 36'(r0); g = 36'(g0); b = 36'(b0); c = 36'(c0);
    case (f)
      4'd0:  return ((r >> 5) << 11) | ((g >> 4) << 5) | (b >> 5);
      4'd1:  return ((r >> 5) << 16) | ((g >> 4) << 8) | (b >> 5);
      4'd2:  return ((r >> 5) << 19) | ((g >> 4) << 10) | ((b >> 5) << 3);
      4'd3:  return ((r >> 4) << 12) | ((g >> 4) << 6) | (b >> 4);
      4'd4:  return ((r >> 4) << 18) | ((g >> 4) << 10) | ((b >> 4) << 2);
      4'd5:  return ((r >> 2) << 16) | ((g >> 2) << 8) | (b >> 2);
      4'd6:  return (c << 10) | r;
      4'd7:  return (m_ext(c) << 12) | m_ext(r);
      4'd8:  return ((c >> 2) << 8) | (r >> 2);
      4'd10: return (m_ext(r) << 24) | (m_ext(g) << 12) | m_ext(b);
      4'd11: return ((c >> 4) << 6) | (r >> 4);
      default: return (r << 20) | (g << 10) | b;
    endcase
  endfunction

  function automatic int m_src(logic [1:0] s);
    return (s == 2'd1) ? 1 : (s == 2'd2) ? 2 : 0;
  endfunction

  task automatic drive_cycle(logic de, logic hs, logic vs, logic [9:0] a, logic [9:0] b,
                             logic [9:0] c, logic [35:0] d, string ctag, string dtag);
    exp_t it;
    pix_de = de ^ cfg_inv_de;
    pix_hs = hs ^ cfg_inv_hs;
    pix_vs = vs ^ cfg_inv_vs;
    pix_c0 = a; pix_c1 = b; pix_c2 = c;
    it.tgt = cyc + 2; it.de = de; it.hs = hs; it.vs = vs;
    it.data = de ? d : 36'd0; it.ctag = ctag; it.dtag = dtag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic blank(int n, string ctag);
    for (int i = 0; i < n; i++) drive_cycle(1'b0, 1'b0, 1'b0, 10'h3ff, 10'h155, 10'h2aa, '0, ctag, ctag);
  endtask

  task automatic send_line(int n, string ctag, string dtag);
    logic [9:0] ra[16], rb[16], rc[16], al[3];
    logic [9:0] ch[3][16];
    drive_cycle(1'b0, 1'b1, 1'b0, '0, '0, '0, '0, ctag, dtag);
    blank(2, ctag);
    for (int i = 0; i < n; i++) begin
      ra[i] = 10'($urandom); rb[i] = 10'($urandom); rc[i] = 10'($urandom);
      al[0] = m_align(ra[i], m_wid, 0);
      al[1] = m_align(rb[i], m_wid, 1);
      al[2] = m_align(rc[i], m_wid, 2);
      for (int k = 0; k < 3; k++) ch[k][i] = al[m_src(m_sel[k])];
    end
    for (int i = 0; i < n; i++) begin
      int e, o;
      logic [9:0] cv;
      e = i - (i % 2);
      o = (e + 1 < n) ? e + 1 : e;
      cv = (i % 2 == 0) ? m_pick(m_chr, ch[1][e], ch[1][o]) : m_pick(m_chr, ch[2][e], ch[2][o]);
      drive_cycle(1'b1, 1'b0, 1'b0, ra[i], rb[i], rc[i],
                  m_pack(m_fmt, ch[0][i], ch[1][i], ch[2][i], cv), ctag, dtag);
    end
    blank(2, ctag);
  endtask

  // Apply new format on the ports and capture it with a VSYNC pulse (R10).
  task automatic new_frame(logic [3:0] f, logic [1:0] w, logic [1:0] cm,
                           logic [1:0] s0, logic [1:0] s1, logic [1:0] s2);
    cfg_out_fmt = f; cfg_in_width = w; cfg_chroma_mode = cm;
    cfg_sel_y = s0; cfg_sel_cb = s1; cfg_sel_cr = s2;
    blank(1, "R10");
    drive_cycle(1'b0, 1'b0, 1'b1, '0, '0, '0, '0, "R10", "R10");
    m_fmt = f; m_wid = w; m_chr = cm; m_sel[0] = s0; m_sel[1] = s1; m_sel[2] = s2;
    drive_cycle(1'b0, 1'b0, 1'b1, '0, '0, '0, '0, "R10", "R10");
    blank(2, "R10");
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      while (q.size() > 0 && q[0].tgt <= cyc) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (it.tgt != cyc || {out_de, out_hs, out_vs} !== {it.de, it.hs, it.vs}) begin
          failures++;
          $display("FAIL %s de/hs/vs act=%b%b%b exp=%b%b%b (cycle %0d)", it.ctag,
                   out_de, out_hs, out_vs, it.de, it.hs, it.vs, cyc);
        end
        checks++;
        if (out_data !== it.data) begin
          failures++;
          $display("FAIL %s data act=%h exp=%h (cycle %0d)", it.dtag, out_data, it.data, cyc);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({out_data, out_de, out_hs, out_vs} !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs act=%h exp=0", {out_data, out_de, out_hs, out_vs});
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1: defaults apply although the ports ask for something else
    send_line(6, "R2", "R1");
    // R11 baseline 30-bit, identity
    new_frame(4'd9, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2);
    send_line(6, "R2", "R6");
    // R5: permuted routing and selector value 3
    new_frame(4'd10, 2'd0, 2'd0, 2'd2, 2'd0, 2'd1);
    send_line(6, "R2", "R5");
    new_frame(4'd9, 2'd0, 2'd0, 2'd3, 2'd3, 2'd1);
    send_line(5, "R2", "R5");
    // R4: narrow inputs
    for (int w = 1; w < 4; w++) begin
      new_frame(4'd9, 2'(w), 2'd0, 2'd1, 2'd2, 2'd0);
      send_line(6, "R2", "R4");
    end
    // R6: RGB layouts
    for (int f = 0; f < 6; f++) begin
      new_frame(4'(f), 2'd0, 2'd0, 2'd0, 2'd1, 2'd2);
      send_line(6, "R2", "R6");
    end
    // R7: 4:2:2 layouts
    new_frame(4'd6, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2); send_line(8, "R2", "R7");
    new_frame(4'd7, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2); send_line(8, "R2", "R7");
    new_frame(4'd8, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2); send_line(8, "R2", "R7");
    new_frame(4'd11, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2); send_line(8, "R2", "R7");
    // R8: chroma modes
    for (int m = 1; m < 4; m++) begin
      new_frame(4'd6, 2'd0, 2'(m), 2'd0, 2'd1, 2'd2);
      send_line(8, "R2", "R8");
    end
    // R9: odd-length lines and a single-pixel line, back to back
    new_frame(4'd6, 2'd1, 2'd1, 2'd0, 2'd1, 2'd2);
    send_line(7, "R2", "R9");
    send_line(1, "R2", "R9");
    new_frame(4'd7, 2'd0, 2'd2, 2'd0, 2'd1, 2'd2);
    send_line(7, "R2", "R9");
    send_line(3, "R2", "R9");
    // R3: all polarities inverted, logical levels held
    cfg_inv_de = 1'b1; cfg_inv_hs = 1'b1; cfg_inv_vs = 1'b1;
    blank(2, "R3");
    new_frame(4'd5, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2);
    send_line(6, "R3", "R3");
    cfg_inv_de = 1'b0; cfg_inv_hs = 1'b0; cfg_inv_vs = 1'b0;
    blank(2, "R3");
    // R10: mid-frame change ignored until next VSYNC edge
    new_frame(4'd9, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2);
    cfg_out_fmt = 4'd0; cfg_in_width = 2'd3; cfg_chroma_mode = 2'd2;
    cfg_sel_y = 2'd2; cfg_sel_cb = 2'd2; cfg_sel_cr = 2'd0;
    send_line(6, "R2", "R10");
    // R11: reserved layouts
    for (int f = 12; f < 16; f++) begin
      new_frame(4'(f), 2'd0, 2'd0, 2'd1, 2'd2, 2'd0);
      send_line(4, "R2", "R11");
    end
    blank(4, "R2");
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R2 scoreboard leftover act=%0d exp=0", q.size());
    end
    finish_run();
  end
endmodule